// File: doc/BRIEF.md
# Occupancy-Ranked Fetch Thread Selector

This block sits in the front end of a simultaneous multithreaded core. Every cycle it decides which hardware thread contexts may fetch from the instruction cache. At most two contexts are granted. Each granted context receives a fetch width, and the two widths together never exceed twice the per-thread fetch width.

A context can be granted only if it is active and has no instruction-cache miss outstanding. Eligible contexts are ranked by a selectable key. In the plain mode, the key is the number of that thread's instructions waiting in the decode, rename and issue-queue stages, and the smallest count wins. Two other modes add a primary key that is compared first, with the occupancy count used only to break ties. In one mode the primary key is the thread's unresolved low-confidence branches. In the other it is the thread's unresolved branches of any kind. If two contexts still tie, the lower context number wins.

A power governor samples an external power estimate at a fixed interval and compares it with a target. When the sampled estimate reaches 110% of the target, fetch stops for every context. Fetch resumes at a later sample that falls below that level.

The ranking logic is combinational, so grants follow the inputs in the same cycle. Only the governor holds state. Its states are `PW_RUN` (fetch allowed) and `PW_HALT` (fetch stopped). At each sample instant there are two transitions:
- an over-threshold sample moves `PW_RUN` to `PW_HALT`;
- an under-threshold sample moves `PW_HALT` back to `PW_RUN`.

Between samples the state holds.

Top module: `fetch_sel`

## Requirements
- R1: At most two grants are issued per cycle. When both are issued, their context numbers differ. `grant1_valid` is never high while `grant0_valid` is low. When no context is eligible, no grant is issued.
- R2: A context is eligible only when its `ctx_active` bit is 1 and its `ctx_miss` bit is 0. An ineligible context is never granted, whatever its counts.
- R3: With `key_mode` = 0 (and with the spare code 3, which behaves the same), contexts are ranked by `occ_cnt` alone, and the smaller value has higher priority.
- R4: With `key_mode` = 1, contexts are ranked first by `lowconf_cnt`, with the smaller value winning. Equal values are ordered by `occ_cnt`, smaller first.
- R5: With `key_mode` = 2, contexts are ranked first by `branch_cnt`, with the smaller value winning. Equal values are ordered by `occ_cnt`, smaller first.
- R6: If two contexts still tie after the mode's keys, the lower context number ranks higher. Grant 0 always carries the best-ranked eligible context and grant 1 the second-best.
- R7: When both grants are valid, each carries a width of FETCH_W (4). When only grant 0 is valid, it carries 2*FETCH_W (8). An invalid grant carries width 0 and context number 0.
- R8: The power estimate is sampled on the first rising clock edge after reset and then on every 5th edge. At a sample, `fetch_halt` becomes 1 if 100*`pwr_est` >= 110*`pwr_target`, and 0 otherwise. Between samples `fetch_halt` does not change.
- R9: While `fetch_halt` is 1, no grant is valid.
- R10: During and directly after reset, `fetch_halt` is 0 and the sampling phase restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_active | input | NUM_CTX | Context holds a running thread |
| ctx_miss | input | NUM_CTX | Context waits on an instruction-cache miss |
| occ_cnt | input | NUM_CTX*OCC_W | Per-context count of instructions in decode, rename and queue stages; context i at bits [i*OCC_W +: OCC_W] |
| lowconf_cnt | input | NUM_CTX*BR_W | Per-context unresolved low-confidence branch count |
| branch_cnt | input | NUM_CTX*BR_W | Per-context unresolved branch count |
| key_mode | input | 2 | Ranking key: 0 occupancy, 1 low-confidence branches, 2 all branches, 3 as 0 |
| pwr_est | input | PWR_W | Current power estimate |
| pwr_target | input | PWR_W | Power target |
| fetch_halt | output | 1 | Fetch stopped for all contexts |
| grant0_valid | output | 1 | First grant present |
| grant0_id | output | ID_W | Context number of the best-ranked grant |
| grant0_width | output | WID_W | Fetch width of grant 0 |
| grant1_valid | output | 1 | Second grant present |
| grant1_id | output | ID_W | Context number of the second grant |
| grant1_width | output | WID_W | Fetch width of grant 1 |

## Verification
Directed patterns target specific corners:
- distinct occupancy counts with one tie, which separates correct ranking from the lowest-number tie rule;
- a best-ranked context that has a miss outstanding, which shows the miss mask is applied before the ranking and not after it;
- one eligible context, and then none, which exercises the width doubling and the empty grant.

Random counts are then run in each of the three modes with small branch counts, so that primary-key ties are frequent and the secondary occupancy key decides many outcomes. Finally, a power estimate that changes every cycle around the 110% level shows whether the halt decision comes from the sample instant or from the live estimate.

// File: rtl/fs_pkg.sv
package fs_pkg;

    // Ranking key selection
    typedef enum logic [1:0] {
        KEY_OCC     = 2'd0,
        KEY_LOWCONF = 2'd1,
        KEY_ALLBR   = 2'd2,
        KEY_SPARE   = 2'd3
    } key_mode_e;

    // Power governor states
    typedef enum logic [0:0] {
        PW_RUN  = 1'b0,
        PW_HALT = 1'b1
    } pw_state_e;

endpackage

// File: rtl/fs_key_gen.sv
module fs_key_gen
    import fs_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int OCC_W   = 6,
    parameter int BR_W    = 4,
    localparam int KEY_W  = BR_W + OCC_W
) (
    input  logic [1:0]               key_mode,
    input  logic [NUM_CTX*OCC_W-1:0] occ_cnt,
    input  logic [NUM_CTX*BR_W-1:0]  lowconf_cnt,
    input  logic [NUM_CTX*BR_W-1:0]  branch_cnt,
    output logic [NUM_CTX*KEY_W-1:0] ctx_key
);

    key_mode_e mode_q;
    assign mode_q = key_mode_e'(key_mode);

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_key
        logic [OCC_W-1:0] occ_c;
        logic [BR_W-1:0]  lc_c;
        logic [BR_W-1:0]  br_c;
        logic [KEY_W-1:0] key_c;

        assign occ_c = occ_cnt[c*OCC_W +: OCC_W];
        assign lc_c  = lowconf_cnt[c*BR_W +: BR_W];
        assign br_c  = branch_cnt[c*BR_W +: BR_W];

        // The primary key occupies the upper bits and occupancy the lower bits,
        // so a single unsigned compare implements the two-level ordering.
        always_comb begin
            unique case (mode_q)
                KEY_LOWCONF: key_c = {lc_c, occ_c};
                KEY_ALLBR:   key_c = {br_c, occ_c};
                KEY_OCC,
                KEY_SPARE:   key_c = {{BR_W{1'b0}}, occ_c};
                default:     key_c = {{BR_W{1'b0}}, occ_c};
            endcase
        end

        assign ctx_key[c*KEY_W +: KEY_W] = key_c;
    end

endmodule

// File: rtl/fs_min_pick.sv
module fs_min_pick #(
    parameter int NUM_CTX = 8,
    parameter int KEY_W   = 10,
    localparam int ID_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic [NUM_CTX-1:0]       cand,
    input  logic [NUM_CTX*KEY_W-1:0] ctx_key,
    output logic                     found,
    output logic [ID_W-1:0]          pick_id
);

    logic [KEY_W-1:0] best_key;

    // Ascending scan with a strict compare: on equal keys, the earlier
    // (lower-numbered) context is kept.
    always_comb begin
        found    = 1'b0;
        pick_id  = '0;
        best_key = '0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (cand[i] && (!found || (ctx_key[i*KEY_W +: KEY_W] < best_key))) begin
                found    = 1'b1;
                pick_id  = ID_W'(i);
                best_key = ctx_key[i*KEY_W +: KEY_W];
            end
        end
    end

endmodule

// File: rtl/fs_power_fsm.sv
module fs_power_fsm
    import fs_pkg::*;
#(
    parameter int PWR_W         = 12,
    parameter int SAMPLE_PERIOD = 5,
    parameter int LIMIT_PCT     = 110,
    localparam int PH_W         = (SAMPLE_PERIOD > 1) ? $clog2(SAMPLE_PERIOD) : 1,
    localparam int PROD_W       = PWR_W + 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PWR_W-1:0] pwr_est,
    input  logic [PWR_W-1:0] pwr_target,
    output logic             halt
);

    pw_state_e        state_q, state_d;
    logic [PH_W-1:0]  phase_q;
    logic             sample_now;
    logic             over_limit;
    logic [PROD_W-1:0] est_scaled;
    logic [PROD_W-1:0] tgt_scaled;

    assign sample_now = (phase_q == '0);
    assign est_scaled = PROD_W'(pwr_est) * PROD_W'(100);
    assign tgt_scaled = PROD_W'(pwr_target) * PROD_W'(LIMIT_PCT);
    assign over_limit = (est_scaled >= tgt_scaled);

    // Sample phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == PH_W'(SAMPLE_PERIOD - 1)) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PW_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_RUN:  if (sample_now && over_limit)  state_d = PW_HALT;
            PW_HALT: if (sample_now && !over_limit) state_d = PW_RUN;
            default: state_d = PW_RUN;
        endcase
    end

    // Output logic
    always_comb begin
        unique case (state_q)
            PW_HALT: halt = 1'b1;
            PW_RUN:  halt = 1'b0;
            default: halt = 1'b0;
        endcase
    end

endmodule

// File: rtl/fetch_sel.sv
module fetch_sel
    import fs_pkg::*;
#(
    parameter int NUM_CTX       = 8,
    parameter int OCC_W         = 6,
    parameter int BR_W          = 4,
    parameter int PWR_W         = 12,
    parameter int FETCH_W       = 4,
    parameter int SAMPLE_PERIOD = 5,
    parameter int LIMIT_PCT     = 110,
    localparam int ID_W         = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int WID_W        = $clog2(2 * FETCH_W + 1),
    localparam int KEY_W        = BR_W + OCC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CTX-1:0]       ctx_active,
    input  logic [NUM_CTX-1:0]       ctx_miss,
    input  logic [NUM_CTX*OCC_W-1:0] occ_cnt,
    input  logic [NUM_CTX*BR_W-1:0]  lowconf_cnt,
    input  logic [NUM_CTX*BR_W-1:0]  branch_cnt,
    input  logic [1:0]               key_mode,
    input  logic [PWR_W-1:0]         pwr_est,
    input  logic [PWR_W-1:0]         pwr_target,
    output logic                     fetch_halt,
    output logic                     grant0_valid,
    output logic [ID_W-1:0]          grant0_id,
    output logic [WID_W-1:0]         grant0_width,
    output logic                     grant1_valid,
    output logic [ID_W-1:0]          grant1_id,
    output logic [WID_W-1:0]         grant1_width
);

    logic [NUM_CTX*KEY_W-1:0] ctx_key;
    logic [NUM_CTX-1:0]       elig;
    logic [NUM_CTX-1:0]       elig_rest;
    logic                     first_found, second_found;
    logic [ID_W-1:0]          first_id, second_id;
    logic                     halt_w;

    assign elig = ctx_active & ~ctx_miss;

    fs_key_gen #(
        .NUM_CTX (NUM_CTX),
        .OCC_W   (OCC_W),
        .BR_W    (BR_W)
    ) u_keys (
        .key_mode    (key_mode),
        .occ_cnt     (occ_cnt),
        .lowconf_cnt (lowconf_cnt),
        .branch_cnt  (branch_cnt),
        .ctx_key     (ctx_key)
    );

    fs_min_pick #(
        .NUM_CTX (NUM_CTX),
        .KEY_W   (KEY_W)
    ) u_pick_first (
        .cand    (elig),
        .ctx_key (ctx_key),
        .found   (first_found),
        .pick_id (first_id)
    );

    // Remove the first winner before picking the runner-up.
    always_comb begin
        elig_rest = elig;
        if (first_found) begin
            elig_rest[first_id] = 1'b0;
        end
    end

    fs_min_pick #(
        .NUM_CTX (NUM_CTX),
        .KEY_W   (KEY_W)
    ) u_pick_second (
        .cand    (elig_rest),
        .ctx_key (ctx_key),
        .found   (second_found),
        .pick_id (second_id)
    );

    fs_power_fsm #(
        .PWR_W         (PWR_W),
        .SAMPLE_PERIOD (SAMPLE_PERIOD),
        .LIMIT_PCT     (LIMIT_PCT)
    ) u_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_est    (pwr_est),
        .pwr_target (pwr_target),
        .halt       (halt_w)
    );

    assign fetch_halt = halt_w;

    // Grant outputs: gated by the governor; a lone grant takes both width shares.
    always_comb begin
        grant0_valid = first_found && !halt_w;
        grant1_valid = second_found && !halt_w;
        grant0_id    = grant0_valid ? first_id : '0;
        grant1_id    = grant1_valid ? second_id : '0;
        if (!grant0_valid) begin
            grant0_width = '0;
        end else if (grant1_valid) begin
            grant0_width = WID_W'(FETCH_W);
        end else begin
            grant0_width = WID_W'(2 * FETCH_W);
        end
        grant1_width = grant1_valid ? WID_W'(FETCH_W) : '0;
    end

endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
    parameter int NUM_CTX       = 8,
    parameter int FETCH_W       = 4,
    parameter int SAMPLE_PERIOD = 5,
    parameter int ID_W          = 3,
    parameter int WID_W         = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CTX-1:0] ctx_active,
    input logic [NUM_CTX-1:0] ctx_miss,
    input logic               fetch_halt,
    input logic               grant0_valid,
    input logic [ID_W-1:0]    grant0_id,
    input logic [WID_W-1:0]   grant0_width,
    input logic               grant1_valid,
    input logic [ID_W-1:0]    grant1_id,
    input logic [WID_W-1:0]   grant1_width
);

    int unsigned chk_phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_phase <= 0;
        else if (chk_phase == SAMPLE_PERIOD - 1) chk_phase <= 0;
        else chk_phase <= chk_phase + 1;
    end

    AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        grant1_valid |-> grant0_valid); // R1
    AST_DISTINCT_IDS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant0_valid && grant1_valid) |-> (grant0_id != grant1_id)); // R1
    AST_FIRST_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant0_valid |-> (ctx_active[grant0_id] && !ctx_miss[grant0_id])); // R2
    AST_SECOND_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant1_valid |-> (ctx_active[grant1_id] && !ctx_miss[grant1_id])); // R2
    AST_PAIR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        grant1_valid |-> (grant0_width == WID_W'(FETCH_W) && grant1_width == WID_W'(FETCH_W))); // R7
    AST_SOLO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (grant0_valid && !grant1_valid) |-> (grant0_width == WID_W'(2 * FETCH_W))); // R7
    AST_HALT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_phase != 1) |-> $stable(fetch_halt)); // R8
    AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_halt |-> (!grant0_valid && !grant1_valid)); // R9

endmodule

bind fetch_sel fs_checker #(
    .NUM_CTX       (NUM_CTX),
    .FETCH_W       (FETCH_W),
    .SAMPLE_PERIOD (SAMPLE_PERIOD),
    .ID_W          (ID_W),
    .WID_W         (WID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctx_active   (ctx_active),
    .ctx_miss     (ctx_miss),
    .fetch_halt   (fetch_halt),
    .grant0_valid (grant0_valid),
    .grant0_id    (grant0_id),
    .grant0_width (grant0_width),
    .grant1_valid (grant1_valid),
    .grant1_id    (grant1_id),
    .grant1_width (grant1_width)
);

// File: tb/sim_fetch_sel.sv
module sim_fetch_sel;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 8;
    localparam int OCC_W = 6;
    localparam int BR_W  = 4;
    localparam int PWR_W = 12;
    localparam int FW    = 4;
    localparam int SP    = 5;
    localparam int WATCHDOG = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] act, miss;
    logic [N*OCC_W-1:0] occ_v;
    logic [N*BR_W-1:0]  lc_v, br_v;
    logic [1:0] mode;
    logic [PWR_W-1:0] est, tgt;
    logic halt, g0v, g1v;
    logic [2:0] g0id, g1id;
    logic [3:0] g0w, g1w;

    int occ_a[N];
    int lc_a[N];
    int br_a[N];

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;
    string tag_override = "";

    // Reference state
    int m_phase = 0;
    bit m_halt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            occ_v[i*OCC_W +: OCC_W] = OCC_W'(occ_a[i]);
            lc_v[i*BR_W +: BR_W]    = BR_W'(lc_a[i]);
            br_v[i*BR_W +: BR_W]    = BR_W'(br_a[i]);
        end
    end

    fetch_sel u0 (
        .clk(clk), .rst_n(rst_n), .ctx_active(act), .ctx_miss(miss),
        .occ_cnt(occ_v), .lowconf_cnt(lc_v), .branch_cnt(br_v), .key_mode(mode),
        .pwr_est(est), .pwr_target(tgt), .fetch_halt(halt),
        .grant0_valid(g0v), .grant0_id(g0id), .grant0_width(g0w),
        .grant1_valid(g1v), .grant1_id(g1id), .grant1_width(g1w)
    );

    // Behavioural model of the governor
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
            m_halt = 0;
        end else begin
            if (m_phase == 0) m_halt = (int'(est) * 100 >= int'(tgt) * 110);
            m_phase = (m_phase + 1) % SP;
        end
    end

    function automatic int rank_key(int i);
        int prim;
        case (mode)
            2'd1: prim = lc_a[i];
            2'd2: prim = br_a[i];
            default: prim = 0;
        endcase
        return prim * 1000 + occ_a[i];
    endfunction

    function automatic int best_excluding(int skip);
        int b = -1;
        for (int i = 0; i < N; i++) begin
            if (i != skip && act[i] && !miss[i]) begin
                if (b < 0 || rank_key(i) < rank_key(b)) b = i;
            end
        end
        return b;
    endfunction

    task automatic check(string tag, int actual, int expected, string what);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, actual, expected, $time);
        end
    endtask

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e0, e1, ev0, ev1, ew0, ew1;
            string gtag;
            e0 = best_excluding(-1);
            e1 = (e0 >= 0) ? best_excluding(e0) : -1;
            ev0 = (e0 >= 0 && !m_halt) ? 1 : 0;
            ev1 = (e1 >= 0 && !m_halt) ? 1 : 0;
            ew0 = ev0 ? (ev1 ? FW : 2 * FW) : 0;
            ew1 = ev1 ? FW : 0;
            if (m_halt) gtag = "R9";
            else if (tag_override != "") gtag = tag_override;
            else if (mode == 2'd1) gtag = "R4";
            else if (mode == 2'd2) gtag = "R5";
            else gtag = "R3";
            check("R8", int'(halt), int'(m_halt), "fetch_halt");
            check(gtag, int'(g0v), ev0, "grant0_valid");
            check(gtag, int'(g1v), ev1, "grant1_valid");
            check(gtag, int'(g0id), ev0 ? e0 : 0, "grant0_id");
            check(gtag, int'(g1id), ev1 ? e1 : 0, "grant1_id");
            check("R7", int'(g0w), ew0, "grant0_width");
            check("R7", int'(g1w), ew1, "grant1_width");
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic set_ctx(int i, bit a, bit m, int o, int l, int b);
        act[i] = a; miss[i] = m; occ_a[i] = o; lc_a[i] = l; br_a[i] = b;
    endtask

    task automatic randomize_ctx(int br_max);
        for (int i = 0; i < N; i++) begin
            set_ctx(i, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) == 0),
                    $urandom_range(0, 12), $urandom_range(0, br_max), $urandom_range(0, br_max));
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) set_ctx(i, 1'b0, 1'b0, 0, 0, 0);
        mode = 2'd0;
        est = 12'd1200;
        tgt = 12'd1000;
        step(3);
        // R10: halt low while reset is held, even with a high estimate
        check("R10", int'(halt), 0, "fetch_halt in reset");
        est = 12'd500;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R10", int'(halt), 0, "fetch_halt after reset");

        // R6: occupancy tie between contexts 1 and 3 -> 1 first, 3 second
        tag_override = "R6";
        for (int i = 0; i < N; i++) set_ctx(i, 1'b1, 1'b0, 9 + i, 0, 0);
        occ_a[1] = 3; occ_a[3] = 3; occ_a[0] = 5;
        step(2);

        // R2: best context has a miss outstanding, second best inactive
        tag_override = "R2";
        miss[1] = 1'b1;
        act[3]  = 1'b0;
        occ_a[6] = 0; miss[6] = 1'b1;
        step(2);

        // R7/R1: a single eligible context, then none
        tag_override = "R1";
        for (int i = 0; i < N; i++) set_ctx(i, 1'b0, 1'b0, 1, 0, 0);
        act[5] = 1'b1;
        step(2);
        act[5] = 1'b0;
        act[2] = 1'b1; miss[2] = 1'b1;
        step(2);
        tag_override = "";

        // Random ranking in every mode, power low
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            for (int k = 0; k < 300; k++) begin
                randomize_ctx(2);
                step(1);
            end
        end

        // Power estimate moving every cycle around the 110% level
        for (int k = 0; k < 600; k++) begin
            randomize_ctx(3);
            mode = 2'($urandom_range(0, 2));
            est = 12'($urandom_range(1090, 1110));
            if (k % 50 == 0) est = 12'd1100;
            step(1);
        end
        est = 12'd100;
        step(12);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule